// File: doc/BRIEF.md
# Single-Wire Auto-Baud Reply Controller

This block is the device side of a one-wire link. Host and device share one open-drain line that a pullup holds high. The host starts a transaction with a trigger sequence. It first pulls the line low to wake the block, then sends a high pulse whose width is the bit time it wants for the reply. It then pulls the line low again and finally lets it float. The block times that high pulse and keeps the width as a count of timing ticks. Once the line is released, it asks the attached measurement engine for a sample. When the sample arrives, the block sends the 16-bit value back on the same wire as two UART frames, with a programmable pause between them.

All timing runs from a single-cycle tick enable that is nominally 1.2 MHz, so one tick is about 0.83 µs. At that rate, 36 ticks is roughly 30 µs. The accepted pulse widths of 125 to 252 ticks cover about 9600 down to 4800 baud. The bit time is learned again on every transaction, so each reply can use a different rate. The block only ever pulls the line low: a logic 1 on the wire means the block has released it.

Top module: `swab_responder`

## Requirements
- R1: During and right after reset, line_oe_n is 1 (line released), acq_req is 0 and err is 0.
- R2: While listening, a falling edge on the line wakes the block. The host must hold the line low for at least 36 ticks before raising it. A wake-low of 35 ticks or fewer is dropped without a trace: no request follows and err does not change.
- R3: line_in passes through two synchronizing flops and one edge-history flop. The width of the host's high pulse is the number of tick-qualified clock edges between the synchronized rising and falling edges. A pulse of H ticks that starts on a tick boundary measures exactly H, and H becomes the reply's bit period in ticks.
- R4: A measured width from 125 to 252 ticks, both inclusive, is accepted. A shorter pulse, or a high phase that reaches a 253rd tick, sets err and produces no request and no reply. err then stays at 1 until the next wake falling edge clears it.
- R5: After the high pulse, the line must stay low for at least 36 ticks and then be released. acq_req rises after the third clock edge that follows the release. A low tail shorter than 36 ticks sets err and produces no request.
- R6: acq_req stays high until acq_done is sampled high. result and gap_set are captured on that same edge, and later changes to them do not affect the reply. acq_done is ignored when no request is pending.
- R7: Each frame is a low start bit, 8 data bits sent LSB first, and a high stop bit. Every bit lasts exactly the learned period in ticks. The first start bit begins on the clock edge where acq_done is sampled. line_oe_n = 0 pulls the line low and line_oe_n = 1 releases it.
- R8: The first frame carries result[15:8] and the second frame carries result[7:0].
- R9: Between the end of the first stop bit and the second start bit, the line stays released for 10 + 4*gap_set ticks.
- R10: After the second stop bit the block listens again and accepts a new trigger. Any line activity during the acquisition or the reply is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle timing enable, nominal 1.2 MHz |
| line_in | input | 1 | Level of the shared wire |
| line_oe_n | output | 1 | 0 pulls the wire low, 1 releases it |
| acq_req | output | 1 | Request for a sample, held until acq_done |
| acq_done | input | 1 | Sample-ready pulse |
| result | input | 16 | Sample value, captured with acq_done |
| gap_set | input | 8 | Inter-frame pause setting, captured with acq_done |
| err | output | 1 | Trigger protocol error, sticky until the next wake |

## Verification
The embedded properties watch several rules on every cycle:
- an accepted bit period always lies inside the legal window;
- the wire is pulled low only while a reply is in progress;
- the output level changes only on a tick or at the start of a reply;
- a request rises only after a valid trigger and is held until it is answered;
- err rises only because of a rejected trigger.

Other behaviour can only be shown by the bench's scenarios. These are the exact tick count taken from the host's pulse and the boundary widths 35/36 and 124/125/252/253. They also include the byte and bit order and the gap length against the bench's queue model, the capture of result and gap_set at acq_done, and the fact that line activity during a reply is ignored.

// File: rtl/swab_pkg.sv
`timescale 1ns/1ps
package swab_pkg;

  typedef enum logic [1:0] {PH_LISTEN, PH_ACQ, PH_SEND} phase_e;
  typedef enum logic [1:0] {TG_IDLE, TG_WAKE, TG_HIGH, TG_TAIL} trig_e;

  // segment numbering of one reply: 0 start, 1..8 high byte, 9 stop,
  // 10 pause, 11 start, 12..19 low byte, 20 stop
  localparam logic [4:0] SEG_PAUSE = 5'd10;
  localparam logic [4:0] SEG_FINAL = 5'd20;

  function automatic int unsigned pause_ticks(int unsigned setting,
                                              int unsigned base,
                                              int unsigned step);
    return base + step * setting;
  endfunction

  // wire level of a reply segment (1 = released)
  function automatic logic seg_level(logic [4:0] seg, logic [15:0] word);
    logic [7:0] byte_v;
    logic [4:0] off;
    logic       lvl;
    byte_v = (seg <= 5'd9) ? word[15:8] : word[7:0];
    off    = (seg <= 5'd9) ? seg - 5'd1 : seg - 5'd12;
    if (seg == 5'd0 || seg == 5'd11)
      lvl = 1'b0;
    else if ((seg >= 5'd1 && seg <= 5'd8) || (seg >= 5'd12 && seg <= 5'd19))
      lvl = byte_v[off[2:0]];
    else
      lvl = 1'b1;
    return lvl;
  endfunction

endpackage

// File: rtl/swab_line_sync.sv
`timescale 1ns/1ps
module swab_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic rise,
  output logic fall
);
  // [0],[1] synchronizer, [2] edge history
  logic [2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= 3'b111;
    else        sh <= {sh[1:0], line_in};
  end

  assign rise = sh[1] & ~sh[2];
  assign fall = ~sh[1] & sh[2];
endmodule

// File: rtl/swab_trigger.sv
`timescale 1ns/1ps
module swab_trigger #(
  parameter int unsigned LOW_MIN = 36,
  parameter int unsigned BIT_MIN = 125,
  parameter int unsigned BIT_MAX = 252,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic             rise,
  input  logic             fall,
  output logic             wake,
  output logic             go,
  output logic             bad,
  output logic [CNT_W-1:0] period
);
  import swab_pkg::*;

  localparam logic [CNT_W-1:0] LOW_LIM = CNT_W'(LOW_MIN);
  localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(BIT_MIN);
  localparam logic [CNT_W-1:0] MAX_LIM = CNT_W'(BIT_MAX);

  trig_e            st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n, period_n;

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    period_n = period;
    wake     = 1'b0;
    go       = 1'b0;
    bad      = 1'b0;
    unique case (st)
      TG_IDLE: if (fall) begin
        st_n  = TG_WAKE;
        cnt_n = '0;
        wake  = 1'b1;
      end
      TG_WAKE: begin
        if (rise) begin
          st_n  = (cnt >= LOW_LIM) ? TG_HIGH : TG_IDLE;
          cnt_n = '0;
        end else if (tick && cnt < LOW_LIM) begin
          cnt_n = cnt + 1'b1;
        end
      end
      TG_HIGH: begin
        if (fall) begin
          if (cnt >= MIN_LIM) begin
            st_n     = TG_TAIL;
            period_n = cnt;
          end else begin
            st_n = TG_IDLE;
            bad  = 1'b1;
          end
          cnt_n = '0;
        end else if (tick) begin
          if (cnt == MAX_LIM) begin
            st_n = TG_IDLE;
            bad  = 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
      end
      TG_TAIL: begin
        if (rise) begin
          st_n = TG_IDLE;
          if (cnt >= LOW_LIM) go = 1'b1;
          else                bad = 1'b1;
        end else if (tick && cnt < LOW_LIM) begin
          cnt_n = cnt + 1'b1;
        end
      end
      default: st_n = TG_IDLE;
    endcase
    if (!enable) begin
      st_n = TG_IDLE;
      wake = 1'b0;
      go   = 1'b0;
      bad  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= TG_IDLE;
      cnt    <= '0;
      period <= '0;
    end else begin
      st     <= st_n;
      cnt    <= cnt_n;
      period <= period_n;
    end
  end

  // R4
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (period >= MIN_LIM && period <= MAX_LIM));
endmodule

// File: rtl/swab_frame_tx.sv
`timescale 1ns/1ps
module swab_frame_tx #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned LEN_W     = 11,
  parameter int unsigned GAP_SET_W = 8,
  parameter int unsigned GAP_BASE  = 10,
  parameter int unsigned GAP_STEP  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 start,
  input  logic [CNT_W-1:0]     bit_ticks,
  input  logic [15:0]          word,
  input  logic [GAP_SET_W-1:0] gap_set,
  output logic                 oe_n,
  output logic                 last
);
  import swab_pkg::*;

  logic             active;
  logic [4:0]       seg;
  logic [LEN_W-1:0] tcnt, gap_q, seg_len;
  logic [CNT_W-1:0] bit_q;
  logic [15:0]      word_q;

  assign seg_len = (seg == SEG_PAUSE) ? gap_q : LEN_W'(bit_q);
  assign last    = active && tick && seg == SEG_FINAL && tcnt == seg_len - LEN_W'(1);
  assign oe_n    = !active || seg_level(seg, word_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      seg    <= '0;
      tcnt   <= '0;
      gap_q  <= '0;
      bit_q  <= '0;
      word_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      seg    <= '0;
      tcnt   <= '0;
      word_q <= word;
      bit_q  <= bit_ticks;
      gap_q  <= LEN_W'(pause_ticks(32'(gap_set), GAP_BASE, GAP_STEP));
    end else if (active && tick) begin
      if (tcnt == seg_len - LEN_W'(1)) begin
        tcnt <= '0;
        if (seg == SEG_FINAL) active <= 1'b0;
        else                  seg    <= seg + 5'd1;
      end else begin
        tcnt <= tcnt + LEN_W'(1);
      end
    end
  end

  // R7
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(oe_n));
  // R7
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (tcnt < seg_len));
endmodule

// File: rtl/swab_responder.sv
`timescale 1ns/1ps
module swab_responder #(
  parameter int unsigned LOW_MIN   = 36,
  parameter int unsigned BIT_MIN   = 125,
  parameter int unsigned BIT_MAX   = 252,
  parameter int unsigned GAP_SET_W = 8,
  parameter int unsigned GAP_BASE  = 10,
  parameter int unsigned GAP_STEP  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 line_in,
  output logic                 line_oe_n,
  output logic                 acq_req,
  input  logic                 acq_done,
  input  logic [15:0]          result,
  input  logic [GAP_SET_W-1:0] gap_set,
  output logic                 err
);
  import swab_pkg::*;

  localparam int unsigned CNT_TOP = (BIT_MAX > LOW_MIN) ? BIT_MAX : LOW_MIN;
  localparam int unsigned CNT_W   = $clog2(CNT_TOP + 1);
  localparam int unsigned GAP_TOP = GAP_BASE + GAP_STEP * ((1 << GAP_SET_W) - 1);
  localparam int unsigned LEN_TOP = (GAP_TOP > CNT_TOP) ? GAP_TOP : CNT_TOP;
  localparam int unsigned LEN_W   = $clog2(LEN_TOP + 1);

  phase_e           phase;
  logic             rise, fall;
  logic             trig_wake, trig_go, trig_bad;
  logic [CNT_W-1:0] period;
  logic             tx_start, tx_last;

  swab_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .rise(rise), .fall(fall)
  );

  swab_trigger #(
    .LOW_MIN(LOW_MIN), .BIT_MIN(BIT_MIN), .BIT_MAX(BIT_MAX), .CNT_W(CNT_W)
  ) u_trig (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(phase == PH_LISTEN),
    .rise(rise), .fall(fall), .wake(trig_wake), .go(trig_go),
    .bad(trig_bad), .period(period)
  );

  assign tx_start = (phase == PH_ACQ) && acq_done;
  assign acq_req  = (phase == PH_ACQ);

  swab_frame_tx #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .GAP_SET_W(GAP_SET_W),
    .GAP_BASE(GAP_BASE), .GAP_STEP(GAP_STEP)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start),
    .bit_ticks(period), .word(result), .gap_set(gap_set),
    .oe_n(line_oe_n), .last(tx_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LISTEN;
    end else begin
      unique case (phase)
        PH_LISTEN: if (trig_go)  phase <= PH_ACQ;
        PH_ACQ:    if (acq_done) phase <= PH_SEND;
        PH_SEND:   if (tx_last)  phase <= PH_LISTEN;
        default:   phase <= PH_LISTEN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err <= 1'b0;
    else if (trig_bad)  err <= 1'b1;
    else if (trig_wake) err <= 1'b0;
  end

  // R6
  req_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_req) |-> $past(trig_go));
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_req && !acq_done) |=> acq_req);
  // R10
  drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe_n |-> (phase == PH_SEND));
  // R4
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(trig_bad));
endmodule

// File: tb/test_swab_responder.sv
`timescale 1ns/1ps
module test_swab_responder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic       tick;
  logic       host_low = 1'b0;
  logic       line;
  logic       line_oe_n, acq_req, err;
  logic       acq_done = 1'b0;
  logic [15:0] result = 16'h0;
  logic [7:0]  gap_set = 8'h0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);
  assign line = !(host_low || !line_oe_n);

  swab_responder i_swab_responder (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line),
    .line_oe_n(line_oe_n), .acq_req(acq_req), .acq_done(acq_done),
    .result(result), .gap_set(gap_set), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference reply: queue of (level, length in ticks, requirement)
  bit          q_lvl[$];
  int          q_len[$];
  string       q_tag[$];
  int          seg_cnt = 0;
  bit          armed = 0;
  logic [15:0] exp_word;
  int          exp_bit, exp_gap;

  task automatic push(input bit lvl, input int len, input string tag);
    q_lvl.push_back(lvl); q_len.push_back(len); q_tag.push_back(tag);
  endtask

  task automatic load_reply();
    push(1'b0, exp_bit, "R3");
    for (int i = 8; i < 16; i++) push(exp_word[i], exp_bit, "R8");
    push(1'b1, exp_bit, "R7");
    push(1'b1, 10 + 4 * exp_gap, "R9");
    push(1'b0, exp_bit, "R7");
    for (int i = 0; i < 8; i++) push(exp_word[i], exp_bit, "R8");
    push(1'b1, exp_bit, "R7");
  endtask

  always @(posedge clk) begin
    if (q_lvl.size() > 0 && tick) begin
      seg_cnt++;
      if (seg_cnt == q_len[0]) begin
        void'(q_lvl.pop_front()); void'(q_len.pop_front()); void'(q_tag.pop_front());
        seg_cnt = 0;
      end
    end
    if (armed && acq_done) begin
      armed = 0;
      seg_cnt = 0;
      load_reply();
    end
  end

  always @(negedge clk) begin
    bit    e;
    string t;
    if (rst_n) begin
      e = (q_lvl.size() > 0) ? q_lvl[0] : 1'b1;
      t = (q_lvl.size() > 0) ? q_tag[0] : "R10";
      chk(line_oe_n === e, t, "line_oe_n per clock", line_oe_n, e);
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  // advance to the next negedge that precedes a tick edge
  task automatic slot();
    @(negedge clk);
    while (tdiv != 2'd3) @(negedge clk);
  endtask

  task automatic hold(input bit low, input int n);
    host_low = low;
    repeat (n) slot();
  endtask

  task automatic txn(input int low_w, input int hi_w, input int tail_w,
                     input int mls, input logic [15:0] word, input bit poke);
    slot();
    gap_set = 8'(mls);
    result  = word;
    hold(1'b1, low_w);
    chk(err == 1'b0, "R4", "err cleared by wake", err, 0);
    hold(1'b0, hi_w);
    hold(1'b1, tail_w);
    host_low = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(acq_req == 1'b0, "R5", "req before third edge", acq_req, 0);
    @(negedge clk);
    chk(acq_req == 1'b1, "R5", "req after release", acq_req, 1);
    repeat (17) @(negedge clk);
    chk(acq_req == 1'b1, "R6", "req held", acq_req, 1);
    exp_word = word; exp_bit = hi_w; exp_gap = mls;
    armed = 1;
    acq_done = 1'b1;
    @(negedge clk);
    acq_done = 1'b0;
    result  = ~word;
    gap_set = 8'(mls) ^ 8'h55;
    chk(acq_req == 1'b0, "R6", "req dropped after done", acq_req, 0);
    if (poke) begin
      repeat (10 * hi_w + 5) slot();
      host_low = 1'b1;
      repeat (20) slot();
      host_low = 1'b0;
    end
    while (q_lvl.size() > 0) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(acq_req == 1'b0, "R10", "no request after reply", acq_req, 0);
    chk(err == 1'b0, "R10", "no error after reply", err, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(line_oe_n == 1'b1, "R1", "oe_n in reset", line_oe_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_oe_n == 1'b1, "R1", "oe_n after reset", line_oe_n, 1);
    chk(acq_req == 1'b0, "R1", "acq_req after reset", acq_req, 0);
    chk(err == 1'b0, "R1", "err after reset", err, 0);

    // R2: 35-tick wake is discarded
    slot();
    hold(1'b1, 35);
    hold(1'b0, 400);
    chk(acq_req == 1'b0, "R2", "short wake gives no request", acq_req, 0);
    chk(err == 1'b0, "R2", "short wake leaves err", err, 0);

    // R2/R5 boundaries at 36 ticks, R3 bit period
    txn(36, 130, 36, 3, 16'h3C96, 1'b0);
    // R4 lower width
    txn(40, 125, 40, 0, 16'h8001, 1'b0);

    // R4 too short
    slot();
    hold(1'b1, 40);
    hold(1'b0, 124);
    hold(1'b1, 40);
    chk(err == 1'b1, "R4", "124-tick pulse rejected", err, 1);
    host_low = 1'b0;
    repeat (100) slot();
    chk(acq_req == 1'b0, "R4", "no request after short pulse", acq_req, 0);
    chk(err == 1'b1, "R4", "err sticky", err, 1);

    // R4 upper width
    txn(40, 252, 40, 148, 16'h5AC3, 1'b0);

    // R4 too long: high reaches a 253rd tick
    slot();
    hold(1'b1, 40);
    chk(err == 1'b0, "R4", "err clear after wake", err, 0);
    hold(1'b0, 253);
    @(negedge clk); @(negedge clk);
    chk(err == 1'b1, "R4", "253-tick pulse rejected", err, 1);
    repeat (50) slot();
    chk(acq_req == 1'b0, "R4", "no request after long pulse", acq_req, 0);

    // R5 short tail
    slot();
    hold(1'b1, 40);
    hold(1'b0, 140);
    hold(1'b1, 35);
    host_low = 1'b0;
    repeat (4) @(negedge clk);
    chk(err == 1'b1, "R5", "35-tick tail rejected", err, 1);
    repeat (100) slot();
    chk(acq_req == 1'b0, "R5", "no request after short tail", acq_req, 0);

    // R6 stray done ignored
    @(negedge clk); acq_done = 1'b1;
    @(negedge clk); acq_done = 1'b0;
    repeat (50) @(negedge clk);
    chk(line_oe_n == 1'b1, "R6", "stray done sends nothing", line_oe_n, 1);
    chk(acq_req == 1'b0, "R6", "stray done no request", acq_req, 0);

    // R10 host activity during the pause is ignored
    txn(40, 140, 40, 40, 16'hE71B, 1'b1);
    // R10 ready again
    txn(38, 200, 50, 1, 16'h4D2F, 1'b0);

    finish_run();
  end
endmodule